// File: doc/BRIEF.md
# Channel-Vector Tensor Layout Transformer

This block reorders a tensor stream from a plain channel-major element order into a layout where channels are bundled into vectors. Elements come in over a valid/ready stream. Within that order, width changes fastest, then height, then depth, then channel. The block places each element in a local buffer at the position it takes in the vectorized layout. In that layout, each run of `CVEC` consecutive channels is interleaved as the innermost dimension, below width. Once every input element has been stored, the whole buffer goes out on a second valid/ready stream in ascending destination order.

The tensor shape (channels, depth, height, width) is sampled from configuration inputs when `start` is accepted. `CVEC` and the maximum shape are elaboration parameters. Before the load phase, the buffer is cleared over the length of the current tensor. When the channel count is not a multiple of `CVEC`, the slots of the missing channels in the last group read back as zero. All offsets count elements, so the mapping is the same for any data width.

Each output element carries its position in the new layout: lane within the channel vector, width, height, depth, and channel-group index. A single-cycle `done` pulse closes each job.

Top module: `cvx_layout_xform`

## Requirements
- R1: After reset, `busy`, `done`, `in_ready` and `out_valid` are all low.
- R2: After an accepted `start`, `in_ready` stays low while the buffer is cleared. The block then accepts exactly C*D*H*W input beats, and `in_ready` never rises again in that job.
- R3: The input beat at logical position (c, d, h, w) appears at destination offset `(((c div CVEC)*D + d)*H + h)*W + w` times `CVEC`, plus `c mod CVEC`.
- R4: Every destination slot whose channel (group*CVEC + lane) is at or beyond C outputs the value zero.
- R5: The output stream has exactly ceil(C/CVEC)*CVEC*D*H*W beats, in ascending offset order. `out_last` is high on the final beat only.
- R6: With each output beat at offset o, `out_lane` = o mod CVEC. `out_w`, `out_h` and `out_d` are the width, height and depth of the spatial index (o div CVEC) mod (D*H*W). `out_grp` = o div (CVEC*D*H*W).
- R7: While `out_valid` is high and `out_ready` is low, the output beat and its coordinates hold unchanged, and nothing is skipped.
- R8: A `start` asserted while `busy` is high has no effect. The running job completes with its original shape and data, even if the configuration inputs change.
- R9: `done` is high for exactly one cycle, the cycle after the final output handshake. `busy` is low from that cycle on.
- R10: Padding slots read zero even when a previous job with more channels wrote data into the same buffer locations.
- R11: With C=3, D=1, H=2, W=2 and CVEC=2, logical element 4 lands at offset 1 and logical element 8 at offset 8. The job outputs 16 beats, and offsets 9, 11, 13 and 15 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job; taken only when idle |
| cfg_c | input | clog2(MAX_C+1) | Channel count, 1..MAX_C |
| cfg_d | input | clog2(MAX_D+1) | Depth, 1..MAX_D |
| cfg_h | input | clog2(MAX_H+1) | Height, 1..MAX_H |
| cfg_w | input | clog2(MAX_W+1) | Width, 1..MAX_W |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Block accepts an input element |
| in_data | input | DW | Input element |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Consumer accepts the output element |
| out_data | output | DW | Output element (zero for padding) |
| out_last | output | 1 | Final element of the job |
| out_lane | output | bits(CVEC) | Lane within the channel vector |
| out_w | output | bits(MAX_W) | Width coordinate |
| out_h | output | bits(MAX_H) | Height coordinate |
| out_d | output | bits(MAX_D) | Depth coordinate |
| out_grp | output | bits(ceil(MAX_C/CVEC)) | Channel-group index |

## Verification
The assertions assume that each accepted `start` carries a shape whose dimensions all lie between one and their parameter maximums. Under that assumption, the incremental destination offset always matches the closed-form formula and stays below the job length. The bench only issues shapes inside the default limits. It drives a bogus `start` with out-of-range-looking values only while `busy` is high, where that `start` must be ignored. Input valid and output ready are throttled by a pseudo-random sequence, so stalls and gaps happen at every phase of a job.

// File: rtl/cvx_pkg.sv
package cvx_pkg;

  typedef enum logic [1:0] {
    CVX_IDLE  = 2'd0,
    CVX_CLEAR = 2'd1,
    CVX_LOAD  = 2'd2,
    CVX_DRAIN = 2'd3
  } cvx_phase_t;

  // Index width for a counter that runs 0..n-1 (at least one bit).
  function automatic int cvx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int cvx_ceil(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // Closed-form destination offset, used by assertions and as the
  // specification of the incremental walker.
  function automatic int cvx_dest(input int c, input int d, input int h,
                                  input int w, input int nd, input int nh,
                                  input int nw, input int cv);
    return ((((c / cv) * nd + d) * nh + h) * nw + w) * cv + (c % cv);
  endfunction

endpackage

// File: rtl/cvx_in_walk.sv
module cvx_in_walk
  import cvx_pkg::*;
#(
  parameter int CVEC  = 2,
  parameter int MAX_C = 8,
  parameter int MAX_D = 2,
  parameter int MAX_H = 4,
  parameter int MAX_W = 4,
  parameter int AW    = 8,
  localparam int CI = cvx_bits(MAX_C),
  localparam int DI = cvx_bits(MAX_D),
  localparam int HI = cvx_bits(MAX_H),
  localparam int WI = cvx_bits(MAX_W),
  localparam int LI = cvx_bits(CVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic [CI-1:0] c_last,
  input  logic [DI-1:0] d_last,
  input  logic [HI-1:0] h_last,
  input  logic [WI-1:0] w_last,
  input  logic [AW-1:0] grp_stride,
  output logic [AW-1:0] dest,
  output logic          final_beat
);

  logic [CI-1:0] c_q;
  logic [DI-1:0] d_q;
  logic [HI-1:0] h_q;
  logic [WI-1:0] w_q;
  logic [LI-1:0] lane_q;
  logic [AW-1:0] gbase_q;
  logic [AW-1:0] spoff_q;

  logic wrap_w, wrap_h, wrap_d, lane_wrap;

  assign wrap_w     = (w_q == w_last);
  assign wrap_h     = wrap_w && (h_q == h_last);
  assign wrap_d     = wrap_h && (d_q == d_last);
  assign lane_wrap  = (lane_q == LI'(CVEC - 1));
  assign final_beat = wrap_d && (c_q == c_last);

  // group base + spatial offset (stride CVEC) + lane: no multiplier chain
  assign dest = gbase_q + spoff_q + AW'(lane_q);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      c_q     <= '0;
      d_q     <= '0;
      h_q     <= '0;
      w_q     <= '0;
      lane_q  <= '0;
      gbase_q <= '0;
      spoff_q <= '0;
    end else if (step) begin
      w_q <= wrap_w ? '0 : w_q + 1'b1;
      if (wrap_w) h_q <= wrap_h ? '0 : h_q + 1'b1;
      if (wrap_h) d_q <= wrap_d ? '0 : d_q + 1'b1;
      spoff_q <= wrap_d ? '0 : spoff_q + AW'(CVEC);
      if (wrap_d) begin
        c_q <= c_q + 1'b1;
        if (lane_wrap) begin
          lane_q  <= '0;
          gbase_q <= gbase_q + grp_stride;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end
    end
  end

  // R3: incremental offset agrees with the closed-form mapping
  a_r3_dest_formula: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (int'(dest) == cvx_dest(int'(c_q), int'(d_q), int'(h_q), int'(w_q),
                                     int'(d_last) + 1, int'(h_last) + 1,
                                     int'(w_last) + 1, CVEC)));

endmodule

// File: rtl/cvx_out_walk.sv
module cvx_out_walk
  import cvx_pkg::*;
#(
  parameter int CVEC  = 2,
  parameter int MAX_D = 2,
  parameter int MAX_H = 4,
  parameter int MAX_W = 4,
  parameter int GMAX  = 4,
  parameter int LW    = 9,
  localparam int DI = cvx_bits(MAX_D),
  localparam int HI = cvx_bits(MAX_H),
  localparam int WI = cvx_bits(MAX_W),
  localparam int GI = cvx_bits(GMAX),
  localparam int LI = cvx_bits(CVEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic [DI-1:0] d_last,
  input  logic [HI-1:0] h_last,
  input  logic [WI-1:0] w_last,
  input  logic [LW-1:0] total_len,
  output logic [LW-1:0] ptr,
  output logic [LI-1:0] lane,
  output logic [WI-1:0] w_idx,
  output logic [HI-1:0] h_idx,
  output logic [DI-1:0] d_idx,
  output logic [GI-1:0] grp,
  output logic          is_last
);

  logic lane_wrap, wrap_w, wrap_h, wrap_d;

  assign lane_wrap = (lane == LI'(CVEC - 1));
  assign wrap_w    = lane_wrap && (w_idx == w_last);
  assign wrap_h    = wrap_w && (h_idx == h_last);
  assign wrap_d    = wrap_h && (d_idx == d_last);
  assign is_last   = (ptr == total_len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      ptr   <= '0;
      lane  <= '0;
      w_idx <= '0;
      h_idx <= '0;
      d_idx <= '0;
      grp   <= '0;
    end else if (step) begin
      ptr  <= ptr + 1'b1;
      lane <= lane_wrap ? '0 : lane + 1'b1;
      if (lane_wrap) w_idx <= wrap_w ? '0 : w_idx + 1'b1;
      if (wrap_w)    h_idx <= wrap_h ? '0 : h_idx + 1'b1;
      if (wrap_h)    d_idx <= wrap_d ? '0 : d_idx + 1'b1;
      if (wrap_d)    grp   <= grp + 1'b1;
    end
  end

  // R6: the lane counter and the read pointer stay in step
  a_r6_lane_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (int'(lane) == (int'(ptr) % CVEC)));

  // R5: pointer advances by one per accepted beat
  a_r5_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && !is_last) |=> (ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/cvx_buf.sv
module cvx_buf #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cvx_layout_xform.sv
module cvx_layout_xform
  import cvx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CVEC  = 2,
  parameter int MAX_C = 8,
  parameter int MAX_D = 2,
  parameter int MAX_H = 4,
  parameter int MAX_W = 4,
  localparam int GMAX  = cvx_ceil(MAX_C, CVEC),
  localparam int DEPTH = GMAX * CVEC * MAX_D * MAX_H * MAX_W,
  localparam int AW    = cvx_bits(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int CNW   = $clog2(MAX_C + 1),
  localparam int DNW   = $clog2(MAX_D + 1),
  localparam int HNW   = $clog2(MAX_H + 1),
  localparam int WNW   = $clog2(MAX_W + 1),
  localparam int CI    = cvx_bits(MAX_C),
  localparam int DI    = cvx_bits(MAX_D),
  localparam int HI    = cvx_bits(MAX_H),
  localparam int WI    = cvx_bits(MAX_W),
  localparam int GI    = cvx_bits(GMAX),
  localparam int LI    = cvx_bits(CVEC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CNW-1:0] cfg_c,
  input  logic [DNW-1:0] cfg_d,
  input  logic [HNW-1:0] cfg_h,
  input  logic [WNW-1:0] cfg_w,
  output logic           busy,
  output logic           done,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic           out_last,
  output logic [LI-1:0]  out_lane,
  output logic [WI-1:0]  out_w,
  output logic [HI-1:0]  out_h,
  output logic [DI-1:0]  out_d,
  output logic [GI-1:0]  out_grp
);

  cvx_phase_t    phase_q;
  logic [CI-1:0] c_m1_q;
  logic [DI-1:0] d_m1_q;
  logic [HI-1:0] h_m1_q;
  logic [WI-1:0] w_m1_q;
  logic [LW-1:0] stride_q;
  logic [LW-1:0] total_q;
  logic [LW-1:0] clr_ptr_q;
  logic          done_q;

  // named internal events
  logic start_ok, clearing, clr_last, in_fire, out_fire, load_end, drain_end;
  logic final_beat;
  logic [AW-1:0] dest;
  logic [LW-1:0] rd_ptr;

  // one-time shape arithmetic at start
  logic [LW-1:0] groups_in, span_in, total_in;
  assign groups_in = (LW'(cfg_c) + LW'(CVEC - 1)) / LW'(CVEC);
  assign span_in   = LW'(cfg_d) * LW'(cfg_h) * LW'(cfg_w) * LW'(CVEC);
  assign total_in  = groups_in * span_in;

  assign start_ok  = start && (phase_q == CVX_IDLE);
  assign clearing  = (phase_q == CVX_CLEAR);
  assign clr_last  = clearing && (clr_ptr_q == total_q - 1'b1);
  assign in_ready  = (phase_q == CVX_LOAD);
  assign out_valid = (phase_q == CVX_DRAIN);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign load_end  = in_fire && final_beat;
  assign drain_end = out_fire && out_last;
  assign busy      = (phase_q != CVX_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= CVX_IDLE;
      c_m1_q    <= '0;
      d_m1_q    <= '0;
      h_m1_q    <= '0;
      w_m1_q    <= '0;
      stride_q  <= '0;
      total_q   <= '0;
      clr_ptr_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= drain_end;
      case (phase_q)
        CVX_IDLE: if (start_ok) begin
          c_m1_q    <= CI'(cfg_c - 1'b1);
          d_m1_q    <= DI'(cfg_d - 1'b1);
          h_m1_q    <= HI'(cfg_h - 1'b1);
          w_m1_q    <= WI'(cfg_w - 1'b1);
          stride_q  <= span_in;
          total_q   <= total_in;
          clr_ptr_q <= '0;
          phase_q   <= CVX_CLEAR;
        end
        CVX_CLEAR: begin
          clr_ptr_q <= clr_ptr_q + 1'b1;
          if (clr_last) phase_q <= CVX_LOAD;
        end
        CVX_LOAD:  if (load_end)  phase_q <= CVX_DRAIN;
        CVX_DRAIN: if (drain_end) phase_q <= CVX_IDLE;
        default: phase_q <= CVX_IDLE;
      endcase
    end
  end

  cvx_in_walk #(
    .CVEC(CVEC), .MAX_C(MAX_C), .MAX_D(MAX_D), .MAX_H(MAX_H), .MAX_W(MAX_W), .AW(AW)
  ) u_in_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (phase_q != CVX_LOAD),
    .step       (in_fire),
    .c_last     (c_m1_q),
    .d_last     (d_m1_q),
    .h_last     (h_m1_q),
    .w_last     (w_m1_q),
    .grp_stride (AW'(stride_q)),
    .dest       (dest),
    .final_beat (final_beat)
  );

  cvx_out_walk #(
    .CVEC(CVEC), .MAX_D(MAX_D), .MAX_H(MAX_H), .MAX_W(MAX_W), .GMAX(GMAX), .LW(LW)
  ) u_out_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (phase_q != CVX_DRAIN),
    .step      (out_fire),
    .d_last    (d_m1_q),
    .h_last    (h_m1_q),
    .w_last    (w_m1_q),
    .total_len (total_q),
    .ptr       (rd_ptr),
    .lane      (out_lane),
    .w_idx     (out_w),
    .h_idx     (out_h),
    .d_idx     (out_d),
    .grp       (out_grp),
    .is_last   (out_last)
  );

  logic          buf_we;
  logic [AW-1:0] buf_waddr;
  logic [DW-1:0] buf_wdata;

  // clear pass writes zeros; load pass writes the mapped element
  assign buf_we    = clearing || in_fire;
  assign buf_waddr = clearing ? AW'(clr_ptr_q) : dest;
  assign buf_wdata = clearing ? '0 : in_data;

  cvx_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (AW'(rd_ptr)),
    .rdata (out_data)
  );

  // R3: every write lands inside the current job length
  a_r3_dest_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> (LW'(dest) < total_q));

  // R4 / R10: padding channels read back zero
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ((int'(out_grp) * CVEC + int'(out_lane)) > int'(c_m1_q)))
      |-> (out_data == '0));

  // R7: a stalled beat holds its data and coordinates
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_lane) && $stable(out_w) && $stable(out_h) &&
      $stable(out_d) && $stable(out_grp) && $stable(out_last)));

  // R9: done follows the final handshake for one cycle
  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    drain_end |=> (done && !busy));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: start while busy leaves the latched shape alone
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(total_q) && $stable(c_m1_q) && $stable(stride_q)));

  // R2: load ends straight into the drain phase with input closed
  a_r2_load_to_drain: assert property (@(posedge clk) disable iff (!rst_n)
    load_end |=> (out_valid && !in_ready));

endmodule

// File: tb/tb_cvx_layout_xform.sv
`timescale 1ns/1ps
module tb_cvx_layout_xform;

  localparam int CV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfg_c = '0;
  logic [1:0]  cfg_d = '0;
  logic [2:0]  cfg_h = '0;
  logic [2:0]  cfg_w = '0;
  logic        busy, done;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_last;
  logic [0:0]  out_lane;
  logic [1:0]  out_w, out_h, out_grp;
  logic [0:0]  out_d;

  cvx_layout_xform dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_c(cfg_c), .cfg_d(cfg_d), .cfg_h(cfg_h), .cfg_w(cfg_w),
    .busy(busy), .done(done),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_lane(out_lane), .out_w(out_w), .out_h(out_h),
    .out_d(out_d), .out_grp(out_grp)
  );

  always #10 clk = ~clk;  // 50 MHz

  int total = 0;
  int bad = 0;
  int run_err = 0;
  logic [15:0] lfsr = 16'hACE1;
  int cap [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      run_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic run_case(input int C, input int D, input int H, input int W,
                          input bit poke);
    int S, G, tot, nin, ii, oo, cyc;
    int r, q, sp, g, ch, ev, ec;
    int prev_data;
    bit prev_stall, extra_ready;
    S = D * H * W;
    G = (C + CV - 1) / CV;
    tot = G * CV * S;
    nin = C * S;
    run_err = 0;
    @(negedge clk);
    cfg_c = 4'(C); cfg_d = 2'(D); cfg_h = 3'(H); cfg_w = 3'(W);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(in_ready == 1'b0, "R2", "in_ready during clear", int'(in_ready), 0);
    chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
    ii = 0; oo = 0; cyc = 0; prev_stall = 0; prev_data = 0; extra_ready = 0;
    while (oo < tot && cyc < 8000) begin
      lfsr = lfsr_next(lfsr);
      in_valid  = (ii < nin) && lfsr[0];
      in_data   = 16'(ii + 1);
      out_ready = lfsr[3] | lfsr[6];
      if (poke && cyc == 2 && busy) begin
        start = 1'b1;
        cfg_c = 4'd1; cfg_d = 2'd2; cfg_h = 3'd4; cfg_w = 3'd4;
      end else begin
        start = 1'b0;
      end
      if (in_ready && ii >= nin) extra_ready = 1;
      if (out_valid) begin
        r  = oo % CV;
        q  = oo / CV;
        sp = q % S;
        g  = q / S;
        ch = g * CV + r;
        ev = (ch < C) ? (ch * S + sp + 1) : 0;
        if (prev_stall)
          chk(int'(out_data) == prev_data, "R7", "held data", int'(out_data), prev_data);
        chk(int'(out_data) == ev, (ch < C) ? "R3" : "R4", "data", int'(out_data), ev);
        ec = (((g * 2 + (sp / (W * H))) * 4 + ((sp / W) % H)) * 4 + (sp % W)) * 2 + r;
        chk(((((int'(out_grp) * 2 + int'(out_d)) * 4 + int'(out_h)) * 4 + int'(out_w)) * 2
             + int'(out_lane)) == ec, "R6", "coords",
            (((int'(out_grp) * 2 + int'(out_d)) * 4 + int'(out_h)) * 4 + int'(out_w)) * 2
             + int'(out_lane), ec);
        chk(out_last == (oo == tot - 1), "R5", "last flag", int'(out_last),
            int'(oo == tot - 1));
        cap[oo] = int'(out_data);
        prev_stall = !out_ready;
        prev_data  = int'(out_data);
        if (out_ready) oo++;
      end else begin
        prev_stall = 0;
      end
      if (in_valid && in_ready) ii++;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    chk(done == 1'b1, "R9", "done after last", int'(done), 1);
    chk(busy == 1'b0, "R9", "busy after last", int'(busy), 0);
    chk(ii == nin, "R2", "inputs accepted", ii, nin);
    chk(!extra_ready, "R2", "ready after final input", int'(extra_ready), 0);
    chk(oo == tot, "R5", "output length", oo, tot);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", int'(done), 0);
    if (poke) chk(run_err == 0, "R8", "job errors with start while busy", run_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
    chk(done == 1'b0, "R1", "done", int'(done), 0);
    chk(in_ready == 1'b0, "R1", "in_ready", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);

    // full-channel job leaves data in slots that the next job pads
    run_case(4, 1, 2, 2, 1'b0);
    chk(cap[9] == 13, "R3", "C=4 slot 9", cap[9], 13);
    run_case(3, 1, 2, 2, 1'b1);
    chk(cap[1] == 5, "R11", "logical 4 at offset 1", cap[1], 5);
    chk(cap[8] == 9, "R11", "logical 8 at offset 8", cap[8], 9);
    for (int k = 9; k < 16; k += 2)
      chk(cap[k] == 0, "R10 R11", "padding slot", cap[k], 0);

    for (int c = 1; c <= 5; c++)
      for (int d = 1; d <= 2; d++)
        for (int h = 1; h <= 3; h++)
          for (int w = 1; w <= 3; w++)
            run_case(c, d, h, w, ((c + h + w) % 3) == 0);

    run_case(8, 2, 4, 4, 1'b1);
    run_case(7, 2, 4, 4, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule